// File: doc/BRIEF.md
# Watchdog Timer with Write-Guarded Control Register

This block supervises software progress. Once enabled, it counts ticks of a slow timebase, nominally about 32 kHz, presented as a one-cycle enable on the system clock. If software does not re-arm it before a programmable number of ticks has passed, it takes a timeout action. In reset mode that action is a fixed-length reset request pulse. In interrupt mode it is a level interrupt that the CPU's global interrupt disable cannot mask.

All configuration sits in one 8-bit control register. The register is guarded: a write lands only if the instruction just before it set the unlock bit. The status bit records that a timeout happened and survives the reset that the watchdog itself requests, so software can see after restart why it restarted. A power-supply-monitor event stops the watchdog.

The CPU reports each instruction boundary with `insn_stb`. On that cycle it also says whether the instruction is the unlock bit-set (`unlock_set`) or a write to the register (`reg_wr`, `reg_wdata`).

Top module: `wdg_guard`

## Requirements
- R1: After an external hardware reset the register reads 0x10 (timeout select 1, watchdog off, unlock clear). `rst_req` and `irq` are low.
- R2: A strobed `unlock_set` makes bit 0 read 1. A register write is accepted only on the very next strobe. Any other strobe clears bit 0 to 0, and a write with no unlock directly before it is discarded. Bit 0 reads 0 after an accepted write, whatever value was written to it.
- R3: Register bits 7..4 hold the timeout select s. For s from 0 to 7, with the enable bit (bit 1) set, the timeout fires on exactly the 2^(BASE_LOG2+s)-th tick after the last enabling write. Cycles with `tick` low do not advance the count.
- R4: An accepted write with bit 1 = 1 restarts the count from zero, even while the watchdog is already running.
- R5: With bit 3 = 0, a timeout raises `rst_req` for exactly RST_CYC clocks. At the same edge the register is reloaded to 0x14: power-on fields, with the status bit (bit 2) set and the watchdog off.
- R6: With bit 3 = 1, a timeout sets bit 2 and raises `irq`. The enable bit stays set and counting restarts. `irq` stays high until an accepted write with bit 2 = 0.
- R7: The status bit is set only by a timeout. It is cleared only by an accepted write with bit 2 = 0 or by a hardware reset. Writing 1 to it leaves it unchanged.
- R8: Select value 8 with the enable bit set fires the timeout action at the clock edge after the enabling write, with no tick needed.
- R9: Select values 9 to 15 never produce a timeout, however many ticks pass.
- R10: A `psm_evt` pulse clears the enable bit. No timeout follows until software enables the watchdog again.
- R11: While the enable bit is 0, neither `rst_req` nor `irq` rises and the status bit is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | External hardware reset, asynchronous, active low |
| tick | input | 1 | Timebase enable, one clock wide per slow tick |
| insn_stb | input | 1 | Instruction boundary strobe |
| unlock_set | input | 1 | The strobed instruction sets the unlock bit |
| reg_wr | input | 1 | The strobed instruction writes the control register |
| reg_wdata | input | 8 | Write data for the control register |
| psm_evt | input | 1 | Power-supply-monitor event pulse |
| reg_rdata | output | 8 | Control register read value |
| rst_req | output | 1 | System reset request pulse |
| irq | output | 1 | Non-maskable timeout interrupt level |

## Verification
The bench goes after the edges of the guarded write. One case is a write with no unlock. Another puts an unrelated instruction between the unlock and the write. A third writes 1 to the unlock bit itself. A design with a loose guard would accept one of these writes and show changed fields. The bench counts ticks to the exact expiry for the shortest, a middle and the longest select, with idle non-tick cycles mixed in. A counter that is off by one, or that counts clocks instead of ticks, would fire one tick early or late. It also checks the re-arm that lands late in a period, the immediate code, a reserved code, a power-monitor stop and a status bit that survives a watchdog reset but not a hardware reset. Each of these exposes a design that fires when it should not, keeps a stale count, or loses the status bit.

// File: rtl/wdg_pkg.sv
package wdg_pkg;
   localparam int          SEL_W       = 4;
   localparam int          NUM_TIMED   = 8;
   localparam logic [3:0]  SEL_NOW     = 4'd8;
   localparam logic [3:0]  SEL_POR     = 4'd1;
   localparam logic [7:0]  CTRL_POR    = 8'h10;
endpackage

// File: rtl/wdg_unlock.sv
module wdg_unlock (
   input  logic clk,
   input  logic rst_n,
   input  logic stb,
   input  logic unlock_set,
   input  logic wr_req,
   input  logic clr,
   output logic armed,
   output logic wr_ok
);
   // a write counts only on the strobe right after the arming strobe
   assign wr_ok = stb & armed & wr_req & ~unlock_set;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       armed <= 1'b0;
      else if (clr)     armed <= 1'b0;
      else if (stb)     armed <= unlock_set;
   end
endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int BASE_LOG2 = 9
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       run,
   input  logic [wdg_pkg::SEL_W-1:0]  tsel,
   input  logic                       tick,
   input  logic                       clr,
   output logic                       expire
);
   import wdg_pkg::*;

   localparam int CW = BASE_LOG2 + NUM_TIMED;

   logic [CW-1:0] cnt;
   logic [CW-1:0] last;
   logic          timed;
   logic          immediate;

   assign timed     = run & (tsel < SEL_NOW);
   assign immediate = run & (tsel == SEL_NOW);
   assign last      = (CW'(1) << (BASE_LOG2 + int'(tsel))) - CW'(1);
   assign expire    = immediate | (timed & tick & (cnt == last));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           cnt <= '0;
      else if (clr || !timed || expire)     cnt <= '0;
      else if (tick)                        cnt <= cnt + CW'(1);
   end
endmodule

// File: rtl/wdg_pulse.sv
module wdg_pulse #(
   parameter int LEN = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   output logic active
);
   generate
      if (LEN == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) active <= 1'b0;
            else        active <= start;
         end
      end else begin : g_count
         localparam int PW = $clog2(LEN + 1);
         logic [PW-1:0] left;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)              left <= '0;
            else if (start)          left <= PW'(LEN);
            else if (left != '0)     left <= left - PW'(1);
         end
         assign active = (left != '0);
      end
   endgenerate
endmodule

// File: rtl/wdg_guard.sv
module wdg_guard #(
   parameter int BASE_LOG2 = 9,
   parameter int RST_CYC   = 16
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       insn_stb,
   input  logic       unlock_set,
   input  logic       reg_wr,
   input  logic [7:0] reg_wdata,
   input  logic       psm_evt,
   output logic [7:0] reg_rdata,
   output logic       rst_req,
   output logic       irq
);
   import wdg_pkg::*;

   generate
      if (BASE_LOG2 < 1) begin : g_bad_base
         $error("wdg_guard: BASE_LOG2 must be at least 1");
      end
      if (RST_CYC < 1) begin : g_bad_len
         $error("wdg_guard: RST_CYC must be at least 1");
      end
   endgenerate

   logic [SEL_W-1:0] tsel;
   logic             irq_mode;
   logic             flag;
   logic             run;
   logic             irq_q;
   logic             armed;
   logic             wr_ok;
   logic             expire;
   logic             fire;
   logic             fire_rst;
   logic             fire_irq;
   logic             kick;
   logic             unused_key;

   assign unused_key = reg_wdata[0];
   assign kick       = wr_ok & reg_wdata[1];
   assign fire       = expire & ~wr_ok;
   assign fire_rst   = fire & ~irq_mode;
   assign fire_irq   = fire & irq_mode;

   wdg_unlock u_unlock (
      .clk        (clk),
      .rst_n      (rst_n),
      .stb        (insn_stb),
      .unlock_set (unlock_set),
      .wr_req     (reg_wr),
      .clr        (fire_rst),
      .armed      (armed),
      .wr_ok      (wr_ok)
   );

   wdg_counter #(.BASE_LOG2(BASE_LOG2)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .tsel   (tsel),
      .tick   (tick),
      .clr    (kick | psm_evt),
      .expire (expire)
   );

   wdg_pulse #(.LEN(RST_CYC)) u_pulse (
      .clk    (clk),
      .rst_n  (rst_n),
      .start  (fire_rst),
      .active (rst_req)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tsel     <= SEL_POR;
         irq_mode <= 1'b0;
         flag     <= 1'b0;
         run      <= 1'b0;
      end else if (fire_rst) begin
         tsel     <= SEL_POR;
         irq_mode <= 1'b0;
         flag     <= 1'b1;
         run      <= 1'b0;
      end else begin
         if (wr_ok) begin
            tsel     <= reg_wdata[7:4];
            irq_mode <= reg_wdata[3];
            run      <= reg_wdata[1];
            if (!reg_wdata[2]) flag <= 1'b0;
         end
         if (fire_irq) flag <= 1'b1;
         if (psm_evt)  run  <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        irq_q <= 1'b0;
      else if (fire_irq)                 irq_q <= 1'b1;
      else if (wr_ok && !reg_wdata[2])   irq_q <= 1'b0;
   end

   assign irq       = irq_q;
   assign reg_rdata = {tsel, irq_mode, flag, run, armed};
endmodule

// File: rtl/wdg_guard_chk.sv
module wdg_guard_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       insn_stb,
   input logic       unlock_set,
   input logic       reg_wr,
   input logic       psm_evt,
   input logic [7:0] reg_rdata,
   input logic       rst_req,
   input logic       irq
);
   // R2
   key_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (insn_stb && !unlock_set) |=> !reg_rdata[0]);

   // R5
   rst_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_req) |-> (reg_rdata == 8'h14));

   // R6
   irq_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> reg_rdata[2]);

   // R7
   flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(reg_rdata[2]) |-> $past(insn_stb && reg_wr));

   // R10
   psm_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      psm_evt |=> !reg_rdata[1]);

   // R11
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !reg_rdata[1] |=> (!$rose(irq) && !$rose(rst_req)));
endmodule

bind wdg_guard wdg_guard_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .insn_stb   (insn_stb),
   .unlock_set (unlock_set),
   .reg_wr     (reg_wr),
   .psm_evt    (psm_evt),
   .reg_rdata  (reg_rdata),
   .rst_req    (rst_req),
   .irq        (irq)
);

// File: tb/tb_wdg_guard.sv
module tb_wdg_guard;
   localparam int BASE = 2;
   localparam int RLEN = 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick = 1'b0;
   logic       insn_stb = 1'b0;
   logic       unlock_set = 1'b0;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic       psm_evt = 1'b0;
   logic [7:0] reg_rdata;
   logic       rst_req;
   logic       irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   wdg_guard #(.BASE_LOG2(BASE), .RST_CYC(RLEN)) dut (
      .clk(clk), .rst_n(rst_n), .tick(tick), .insn_stb(insn_stb),
      .unlock_set(unlock_set), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
      .psm_evt(psm_evt), .reg_rdata(reg_rdata), .rst_req(rst_req), .irq(irq)
   );

   task automatic check(input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", what, act, exp);
      end
   endtask

   task automatic insn(input bit u, input bit w, input logic [7:0] d);
      insn_stb = 1'b1; unlock_set = u; reg_wr = w; reg_wdata = d;
      @(negedge clk);
      insn_stb = 1'b0; unlock_set = 1'b0; reg_wr = 1'b0; reg_wdata = 8'h00;
   endtask

   task automatic wr_ctl(input logic [7:0] d);
      insn(1'b1, 1'b0, 8'h00);
      insn(1'b0, 1'b1, d);
   endtask

   task automatic ticks(input int n);
      for (int i = 0; i < n; i++) begin
         tick = 1'b1;
         @(negedge clk);
         tick = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic hw_reset();
      rst_n = 1'b0;
      idle(2);
      rst_n = 1'b1;
      idle(1);
   endtask

   task automatic t_reset();
      check("R1 reset value", reg_rdata, 8'h10);
      check("R1 rst_req low", rst_req, 0);
      check("R1 irq low", irq, 0);
   endtask

   task automatic t_guard();
      insn(1'b0, 1'b1, 8'h72);
      check("R2 unguarded write discarded", reg_rdata, 8'h10);
      insn(1'b1, 1'b0, 8'h00);
      check("R2 unlock reads back", reg_rdata, 8'h11);
      insn(1'b0, 1'b0, 8'h00);
      check("R2 intervening insn disarms", reg_rdata, 8'h10);
      insn(1'b0, 1'b1, 8'h72);
      check("R2 late write discarded", reg_rdata, 8'h10);
      wr_ctl(8'h31);
      check("R2 accepted write, unlock reads 0", reg_rdata, 8'h30);
      wr_ctl(8'h10);
      check("R2 restore", reg_rdata, 8'h10);
   endtask

   task automatic t_timeout_reset();
      wr_ctl(8'h02);
      ticks(3);
      idle(10);
      check("R3 no fire before 4th tick", rst_req, 0);
      ticks(1);
      check("R3 fire on 4th tick", rst_req, 1);
      check("R5 reload with status", reg_rdata, 8'h14);
      idle(2);
      check("R5 pulse still high", rst_req, 1);
      idle(1);
      check("R5 pulse length", rst_req, 0);
   endtask

   task automatic t_status();
      wr_ctl(8'h14);
      check("R7 write 1 keeps status", reg_rdata, 8'h14);
      wr_ctl(8'h10);
      check("R7 write 0 clears status", reg_rdata, 8'h10);
      wr_ctl(8'h14);
      check("R7 write 1 does not set status", reg_rdata, 8'h10);
   endtask

   task automatic t_kick();
      wr_ctl(8'h12);
      ticks(6);
      wr_ctl(8'h12);
      ticks(7);
      check("R4 kick restarts count", rst_req, 0);
      ticks(1);
      check("R4 fire 8 ticks after kick", rst_req, 1);
      idle(6);
      wr_ctl(8'h10);
   endtask

   task automatic t_irq();
      wr_ctl(8'h0A);
      ticks(3);
      check("R6 no irq early", irq, 0);
      ticks(1);
      check("R6 irq raised", irq, 1);
      check("R6 no reset in irq mode", rst_req, 0);
      check("R6 status set, still running", reg_rdata, 8'h0E);
      ticks(4);
      check("R6 irq held", irq, 1);
      wr_ctl(8'h0A);
      check("R6 irq cleared by status write", irq, 0);
      check("R6 register after clear", reg_rdata, 8'h0A);
      wr_ctl(8'h10);
   endtask

   task automatic t_long();
      wr_ctl(8'h32);
      ticks(31);
      check("R3 select 3 before expiry", rst_req, 0);
      ticks(1);
      check("R3 select 3 expiry", rst_req, 1);
      idle(6);
      wr_ctl(8'h7A);
      ticks(511);
      check("R3 select 7 before expiry", irq, 0);
      ticks(1);
      check("R3 select 7 expiry", irq, 1);
      wr_ctl(8'h10);
      check("R3 cleanup", irq, 0);
   endtask

   task automatic t_now();
      wr_ctl(8'h82);
      check("R8 not yet fired", rst_req, 0);
      check("R8 register armed", reg_rdata, 8'h82);
      idle(1);
      check("R8 immediate reset", rst_req, 1);
      check("R8 status set", reg_rdata, 8'h14);
      idle(6);
      wr_ctl(8'h10);
   endtask

   task automatic t_reserved();
      wr_ctl(8'h92);
      ticks(40);
      idle(20);
      check("R9 no reset", rst_req, 0);
      check("R9 no irq", irq, 0);
      check("R9 register kept", reg_rdata, 8'h92);
      wr_ctl(8'h10);
   endtask

   task automatic t_psm();
      wr_ctl(8'h12);
      ticks(5);
      psm_evt = 1'b1;
      @(negedge clk);
      psm_evt = 1'b0;
      check("R10 enable cleared", reg_rdata, 8'h10);
      ticks(20);
      check("R10 no later timeout", rst_req, 0);
   endtask

   task automatic t_disabled();
      wr_ctl(8'h08);
      ticks(30);
      check("R11 no irq when off", irq, 0);
      check("R11 no reset when off", rst_req, 0);
      check("R11 status clear when off", reg_rdata, 8'h08);
      wr_ctl(8'h10);
   endtask

   task automatic t_hw_clear();
      wr_ctl(8'h02);
      ticks(4);
      check("R7 timeout before hw reset", reg_rdata, 8'h14);
      hw_reset();
      check("R7 hw reset clears status", reg_rdata, 8'h10);
      check("R1 pulse cut by hw reset", rst_req, 0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung expected done");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      idle(3);
      rst_n = 1'b1;
      idle(1);
      t_reset();
      t_guard();
      t_timeout_reset();
      t_status();
      t_kick();
      t_irq();
      t_long();
      t_now();
      t_reserved();
      t_psm();
      t_disabled();
      t_hw_clear();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule